// File: doc/BRIEF.md
# Interleave Bit-Removal Address Normalizer

This block turns a system address that has already matched a memory routing rule into the address as seen by one memory channel. First it takes away the rule's base address. When hoisting is enabled and the address lies at or above the 4 GiB boundary, it also takes away the size of the I/O hole that sits below that boundary. It then deletes the address bits that interleaving used to pick the channel, socket and die, and closes each gap by moving the higher bits down.

The deleted bits need not form one contiguous field. In the hash modes, one group starts at the rule's start bit and a second group starts at bit 12. The bits between the two groups move down by fewer places than the bits above the second group. Every request carries its own rule settings: base, hole size, hoist enable, start bit, mode and bit counts. A single output register holds the result. Requests enter and results leave over valid/ready handshakes. A request is taken when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A result that is not yet taken stays unchanged on the output.

Top module: `addr_normalizer`

## Requirements
- R1: The working offset is `in_addr - in_base`. When `in_hoist_en` is 1 and `in_addr` is at or above 2^32, `in_hole_size` is also subtracted from it. Otherwise the hole size is ignored.
- R2: Mode 0 (linear), and the reserved codes 6 and 7, delete N = chan + die + sock contiguous bits starting at the start bit.
- R3: Mode 1 (legacy hash) deletes the start bit and also bits 12 up to 12+chan-2. With chan = 0 it deletes nothing.
- R4: Mode 2 (hash) and mode 4 (hash 2K) give the same result. Each uses T = chan + sock, and deletes the start bit and bits 12 up to 12+T-2.
- R5: Mode 3 (hash 1K) uses T = chan + sock. It deletes the start bit and, when T ≥ 2, the bit above it. It also deletes bits 12 up to 12+T-3.
- R6: Mode 5 (six-channel) deletes the three bits start, start+1 and start+2. The start bit is 11 or 12.
- R7: Bits kept below every deleted bit keep their position. Each other kept bit moves down by the number of deleted bits below it. The topmost result bits left empty by this are zero.
- R8: `out_underflow` is 1 with a result exactly when that request had `in_addr < in_base`. It is 0 while `out_valid` is 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and the outputs hold their values.
- R10: A request accepted at a clock edge appears on the output with `out_valid` high after that edge. If the output is taken and no request comes in, `out_valid` falls.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_addr | input | 64 | System address |
| in_base | input | 64 | Base address of the matched rule |
| in_hole_size | input | 64 | Size of the I/O hole below 4 GiB |
| in_hoist_en | input | 1 | Subtract the hole for addresses at or above 4 GiB |
| in_start_bit | input | 6 | Lowest interleave bit |
| in_mode | input | 3 | Removal mode code (R2 to R6) |
| in_chan_bits | input | 3 | Channel select bit count |
| in_die_bits | input | 3 | Die select bit count (linear mode only) |
| in_sock_bits | input | 3 | Socket select bit count |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 64 | Channel-relative address |
| out_underflow | output | 1 | Address lay below the rule base |

## Verification
The assertions check the handshake rules on every cycle. These are: the output stays stable under back-pressure, the output becomes valid after an accept, it empties after a drain, and the underflow flag is never high without a valid result. On every cycle they also check that the top bits freed by each bit squeeze are zero. Only the bench's scenarios can show which bits each mode deletes for each start bit and bit count, and that hole hoisting depends on the 4 GiB boundary and the enable. For this the bench compares each result with a separate model, built from the bit positions named in the requirements.

// File: rtl/addr_norm_pkg.sv
package addr_norm_pkg;
  localparam int ADDR_W    = 64;
  localparam int POS_W     = $clog2(ADDR_W);
  localparam int CNT_W     = 3;
  localparam int LEN_W     = CNT_W + 2;
  localparam int HI_GROUP  = 12;
  localparam int HOLE_EDGE = 32;

  typedef enum logic [2:0] {
    MODE_LINEAR = 3'd0,
    MODE_LEGACY = 3'd1,
    MODE_HASH   = 3'd2,
    MODE_HASH1K = 3'd3,
    MODE_HASH2K = 3'd4,
    MODE_SIX    = 3'd5
  } rm_mode_e;

  typedef struct packed {
    logic [POS_W-1:0] pos;
    logic [LEN_W-1:0] len;
  } rm_run_t;
endpackage

// File: rtl/addr_norm_offset.sv
module addr_norm_offset #(
  parameter int W      = 64,
  parameter int EDGE_B = 32
) (
  input  logic [W-1:0] addr_i,
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] hole_i,
  input  logic         hoist_i,
  output logic [W-1:0] offset_o,
  output logic         under_o
);
  logic [W:0]   diff_ext;
  logic         above_edge;

  always_comb begin
    diff_ext   = {1'b0, addr_i} - {1'b0, base_i};
    above_edge = (addr_i >> EDGE_B) != '0;
    under_o    = diff_ext[W];
    offset_o   = diff_ext[W-1:0];
    if (hoist_i && above_edge) offset_o = diff_ext[W-1:0] - hole_i;
  end
endmodule

// File: rtl/addr_norm_runs.sv
module addr_norm_runs
  import addr_norm_pkg::*;
(
  input  logic [2:0]       mode_i,
  input  logic [POS_W-1:0] start_i,
  input  logic [CNT_W-1:0] chan_i,
  input  logic [CNT_W-1:0] die_i,
  input  logic [CNT_W-1:0] sock_i,
  output rm_run_t          lo_run_o,
  output rm_run_t          hi_run_o
);
  logic [LEN_W-1:0] all_bits, hash_bits, chan_ext;
  rm_mode_e         mode;

  always_comb begin
    mode      = rm_mode_e'(mode_i);
    chan_ext  = LEN_W'(chan_i);
    all_bits  = LEN_W'(chan_i) + LEN_W'(die_i) + LEN_W'(sock_i);
    hash_bits = LEN_W'(chan_i) + LEN_W'(sock_i);
    lo_run_o.pos = start_i;
    lo_run_o.len = all_bits;
    hi_run_o.pos = POS_W'(HI_GROUP);
    hi_run_o.len = '0;
    case (mode)
      MODE_LEGACY: begin
        lo_run_o.len = (chan_ext != 0) ? LEN_W'(1) : '0;
        hi_run_o.len = (chan_ext > 1) ? chan_ext - LEN_W'(1) : '0;
      end
      MODE_HASH, MODE_HASH2K: begin
        lo_run_o.len = (hash_bits != 0) ? LEN_W'(1) : '0;
        hi_run_o.len = (hash_bits > 1) ? hash_bits - LEN_W'(1) : '0;
      end
      MODE_HASH1K: begin
        lo_run_o.len = (hash_bits > 2) ? LEN_W'(2) : hash_bits;
        hi_run_o.len = (hash_bits > 2) ? hash_bits - LEN_W'(2) : '0;
      end
      MODE_SIX: lo_run_o.len = LEN_W'(3);
      default: ;
    endcase
  end
endmodule

// File: rtl/addr_norm_squeeze.sv
module addr_norm_squeeze #(
  parameter int W   = 64,
  parameter int PW  = 6,
  parameter int LW  = 5
) (
  input  logic [W-1:0]  data_i,
  input  logic [PW-1:0] pos_i,
  input  logic [LW-1:0] len_i,
  output logic [W-1:0]  data_o
);
  localparam int SH_W = PW + LW + 1;
  logic [SH_W-1:0] skip;
  logic [W-1:0]    keep_mask;

  always_comb begin
    skip      = SH_W'(pos_i) + SH_W'(len_i);
    keep_mask = ~({W{1'b1}} << pos_i);
    data_o    = (data_i & keep_mask) | ((data_i >> skip) << pos_i);
  end

  // R7: freed top bits must read as zero
  always_comb begin
    if (len_i != '0 && (int'(pos_i) + int'(len_i) <= W))
      a_r7_top_zero: assert ((data_o >> (W - int'(len_i))) == '0);
  end
endmodule

// File: rtl/addr_normalizer.sv
module addr_normalizer
  import addr_norm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [ADDR_W-1:0] in_hole_size,
  input  logic              in_hoist_en,
  input  logic [POS_W-1:0]  in_start_bit,
  input  logic [2:0]        in_mode,
  input  logic [CNT_W-1:0]  in_chan_bits,
  input  logic [CNT_W-1:0]  in_die_bits,
  input  logic [CNT_W-1:0]  in_sock_bits,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_underflow
);
  localparam int STAGES = 2;

  logic [ADDR_W-1:0] offset;
  logic              under;
  rm_run_t           lo_run, hi_run;
  rm_run_t           runs [STAGES];
  logic [ADDR_W-1:0] stage_d [STAGES+1];

  addr_norm_offset #(.W(ADDR_W), .EDGE_B(HOLE_EDGE)) u_offset (
    .addr_i(in_addr), .base_i(in_base), .hole_i(in_hole_size),
    .hoist_i(in_hoist_en), .offset_o(offset), .under_o(under)
  );

  addr_norm_runs u_runs (
    .mode_i(in_mode), .start_i(in_start_bit), .chan_i(in_chan_bits),
    .die_i(in_die_bits), .sock_i(in_sock_bits),
    .lo_run_o(lo_run), .hi_run_o(hi_run)
  );

  // higher group first so lower positions stay put for the second squeeze
  assign runs[0]    = hi_run;
  assign runs[1]    = lo_run;
  assign stage_d[0] = offset;

  for (genvar g = 0; g < STAGES; g++) begin : g_squeeze
    addr_norm_squeeze #(.W(ADDR_W), .PW(POS_W), .LW(LEN_W)) u_sq (
      .data_i(stage_d[g]), .pos_i(runs[g].pos), .len_i(runs[g].len),
      .data_o(stage_d[g+1])
    );
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_addr      <= '0;
      out_underflow <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr      <= stage_d[STAGES];
        out_underflow <= under;
      end else begin
        out_underflow <= 1'b0;
      end
    end
  end

  // R9: a stalled result holds
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_underflow));
  // R10: an accepted request shows up after one edge
  a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R10: a drain with no new request empties the output
  a_r10_drain: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);
  // R8: flag only with a result
  a_r8_flag_gated: assert property (@(posedge clk) disable iff (!rst_n)
    out_underflow |-> out_valid);
endmodule

// File: tb/addr_normalizer_tb.sv
`timescale 1ns/1ps
module addr_normalizer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_addr = '0, in_base = '0, in_hole_size = '0;
  logic        in_hoist_en = 1'b0;
  logic [5:0]  in_start_bit = '0;
  logic [2:0]  in_mode = '0;
  logic [2:0]  in_chan_bits = '0, in_die_bits = '0, in_sock_bits = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_addr;
  logic        out_underflow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  addr_normalizer u_dut (
    .clk, .rst_n, .in_valid, .in_ready, .in_addr, .in_base, .in_hole_size,
    .in_hoist_en, .in_start_bit, .in_mode, .in_chan_bits, .in_die_bits,
    .in_sock_bits, .out_valid, .out_ready, .out_addr, .out_underflow
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent model: mark deleted positions, then pack the survivors
  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b,
      logic [63:0] h, logic he, int s, int md, int c, int d, int k);
    logic [63:0] off, del, r;
    int t, j;
    off = a - b;
    if (he && a >= 64'h1_0000_0000) off = off - h;
    del = '0;
    t = c + k;
    case (md)
      1: begin
        if (c > 0) del[s] = 1'b1;
        for (int i = 0; i < c - 1; i++) del[12+i] = 1'b1;
      end
      2, 4: begin
        if (t > 0) del[s] = 1'b1;
        for (int i = 0; i < t - 1; i++) del[12+i] = 1'b1;
      end
      3: begin
        if (t > 0) del[s] = 1'b1;
        if (t > 1) del[s+1] = 1'b1;
        for (int i = 0; i < t - 2; i++) del[12+i] = 1'b1;
      end
      5: for (int i = 0; i < 3; i++) del[s+i] = 1'b1;
      default: for (int i = 0; i < c + d + k; i++) del[s+i] = 1'b1;
    endcase
    r = '0;
    j = 0;
    for (int i = 0; i < 64; i++) if (!del[i]) begin r[j] = off[i]; j++; end
    return r;
  endfunction

  task automatic send(logic [63:0] a, logic [63:0] b, logic [63:0] h,
      logic he, int s, int md, int c, int d, int k);
    @(negedge clk);
    in_addr = a; in_base = b; in_hole_size = h; in_hoist_en = he;
    in_start_bit = 6'(s); in_mode = 3'(md);
    in_chan_bits = 3'(c); in_die_bits = 3'(d); in_sock_bits = 3'(k);
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_case(string req, logic [63:0] a, logic [63:0] b,
      logic [63:0] h, logic he, int s, int md, int c, int d, int k);
    send(a, b, h, he, s, md, c, d, k);
    check({req, " valid"}, 64'(out_valid), 64'd1);
    check(req, out_addr, model(a, b, h, he, s, md, c, d, k));
  endtask

  task automatic t_reset();
    check("R11 out_valid", 64'(out_valid), 64'd0);
    check("R11 in_ready", 64'(in_ready), 64'd1);
  endtask

  task automatic t_linear();
    run_case("R2 linear s9 n4", 64'h0123_4567_89AB_CDEF, 0, 0, 0, 9, 0, 2, 1, 1);
    check("R2 literal", out_addr,
          ((64'h0123_4567_89AB_CDEF >> 13) << 9) | (64'h0123_4567_89AB_CDEF & 64'h1FF));
    run_case("R2 reserved code7", 64'hFEDC_BA98_7654_3210, 0, 0, 0, 8, 7, 3, 0, 0);
  endtask

  task automatic t_legacy();
    run_case("R3 legacy s9 c3", 64'hA5A5_5A5A_F0F0_3C3C, 0, 0, 0, 9, 1, 3, 0, 0);
    run_case("R3 legacy c0", 64'h0000_0000_0000_3FFF, 0, 0, 0, 9, 1, 0, 0, 0);
    check("R3 nothing removed", out_addr, 64'h3FFF);
  endtask

  task automatic t_hash();
    logic [63:0] r2;
    run_case("R4 hash s8 c3 k1", 64'h1357_9BDF_2468_ACE0, 0, 0, 0, 8, 2, 3, 0, 1);
    r2 = out_addr;
    run_case("R4 hash2k same", 64'h1357_9BDF_2468_ACE0, 0, 0, 0, 8, 4, 3, 0, 1);
    check("R4 2k equals hash", out_addr, r2);
    run_case("R4 hash no socket", 64'h0000_FFFF_0000_7F7F, 0, 0, 0, 8, 2, 2, 0, 0);
  endtask

  task automatic t_hash1k();
    run_case("R5 1k s8 t4", 64'hDEAD_BEEF_CAFE_F00D, 0, 0, 0, 8, 3, 4, 0, 0);
    run_case("R5 1k t1", 64'h0000_0000_0000_FFFF, 0, 0, 0, 8, 3, 1, 0, 0);
  endtask

  task automatic t_six();
    run_case("R6 six s11", 64'h0F0F_0F0F_0F0F_7FFF, 0, 0, 0, 11, 5, 0, 0, 0);
    run_case("R6 six s12", 64'h0F0F_0F0F_0F0F_7FFF, 0, 0, 0, 12, 5, 0, 0, 0);
  endtask

  task automatic t_offset();
    run_case("R1 base", 64'h0000_0002_0000_1000, 64'h0000_0001_0000_0000, 0, 0, 8, 0, 0, 0, 0);
    check("R1 base literal", out_addr, 64'h0000_0001_0000_1000);
    run_case("R1 hoist above", 64'h0000_0002_0000_0000, 0, 64'h8000_0000, 1, 8, 0, 0, 0, 0);
    check("R1 hoist literal", out_addr, 64'h0000_0001_8000_0000);
    run_case("R1 hoist below ignored", 64'h0000_0000_7000_0000, 0, 64'h8000_0000, 1, 8, 0, 0, 0, 0);
    check("R1 below literal", out_addr, 64'h7000_0000);
    run_case("R1 hoist off ignored", 64'h0000_0002_0000_0000, 0, 64'h8000_0000, 0, 8, 0, 0, 0, 0);
    check("R1 off literal", out_addr, 64'h0000_0002_0000_0000);
  endtask

  task automatic t_topfill();
    run_case("R7 top zero", 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 9, 0, 2, 1, 1);
    check("R7 top literal", out_addr, 64'h0FFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_underflow();
    send(64'h100, 64'h200, 0, 0, 8, 0, 0, 0, 0);
    check("R8 flag set", 64'(out_underflow), 64'd1);
    send(64'h300, 64'h200, 0, 0, 8, 0, 0, 0, 0);
    check("R8 flag clear", 64'(out_underflow), 64'd0);
    @(negedge clk);
    check("R10 drained", 64'(out_valid), 64'd0);
    check("R8 flag idle", 64'(out_underflow), 64'd0);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    in_addr = 64'h1111; in_base = 0; in_hoist_en = 0; in_mode = 0;
    in_start_bit = 8; in_chan_bits = 0; in_die_bits = 0; in_sock_bits = 0;
    in_valid = 1'b1;
    @(negedge clk);
    check("R10 first out", out_addr, 64'h1111);
    in_addr = 64'h2222;
    check("R9 not ready", 64'(in_ready), 64'd0);
    @(negedge clk);
    check("R9 held addr", out_addr, 64'h1111);
    check("R9 held valid", 64'(out_valid), 64'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 next out", out_addr, 64'h2222);
    @(negedge clk);
    check("R10 empty", 64'(out_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_linear();
    t_legacy();
    t_hash();
    t_hash1k();
    t_six();
    t_offset();
    t_topfill();
    t_underflow();
    t_backpressure();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule